// File: doc/BRIEF.md
# Memory Instruction Issue Queue with Address Ordering

This block holds memory instructions (loads and stores) between decode and the load/store unit of an out-of-order core. Decode writes entries in program order. Each entry records whether it is a load or a store, and which physical register its operand waits on. The queue answers with the slot number it assigned, and that slot number is the handle used for every later event on the entry. An address unit writes the computed address into a slot, and a result broadcast bus marks waiting operands as available.

Each cycle the queue offers at most one entry to the load/store unit. The candidate must have its operand and its address. It must also pass an ordering check against the stores that precede it. A load waits while any older store still lacks an address. A store also waits while an older store, issued or not, holds the same address. Among the candidates, the oldest one wins, so younger work can overtake stalled older work. Entries leave from the oldest end when their instructions commit, up to four per cycle. A misprediction cuts off every entry younger than a named slot, and the cut applies to selection in the same cycle.

Top module: `mem_addr_queue`

## Requirements
- R1: `alloc_ready` is low while all 16 slots are occupied. An `alloc_valid` presented in that state creates no entry and does not change the occupancy.
- R2: An entry is not offered until its operand is ready and its address has been written. The operand counts as ready if it is flagged ready at allocation, or if `cdb_valid` carries a matching `cdb_tag` at or after allocation. An address write to the slot arrives on `agu_valid`.
- R3: A load (`alloc_is_store` = 0) is not offered while any older live store has no address yet.
- R4: A store (`alloc_is_store` = 1) is not offered while an older live store lacks an address or holds an equal address. An older store stays live until it commits.
- R5: An eligible entry is offered even when older entries are still waiting, so issue may leave program order.
- R6: When several entries are eligible, the one closest to the oldest end is offered. An entry is offered exactly once.
- R7: With `flush_valid` high, all entries younger than `flush_slot` are removed and cannot be offered in that cycle. Any allocation request in that cycle is dropped, and the next slot handed out is `flush_slot` + 1 (mod 16).
- R8: `commit_cnt` (0 to 4) releases that many oldest entries at the clock edge. After any non-zero release, `alloc_ready` is high on the next cycle.
- R9: After reset the queue is empty: `alloc_ready` = 1, `issue_valid` = 0, `alloc_slot` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Decode presents a memory instruction |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_src_tag | input | 6 | Physical register the operand waits on |
| alloc_src_rdy | input | 1 | Operand already available at allocation |
| alloc_ready | output | 1 | A free slot exists (decode stalls when low) |
| alloc_slot | output | 4 | Slot that the next allocation receives |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | 6 | Physical register being broadcast |
| agu_valid | input | 1 | Address write valid |
| agu_slot | input | 4 | Slot receiving the address |
| agu_addr | input | 32 | Computed address |
| issue_valid | output | 1 | An entry is offered to the load/store unit this cycle |
| issue_slot | output | 4 | Slot of the offered entry |
| issue_is_store | output | 1 | Kind of the offered entry |
| issue_addr | output | 32 | Address of the offered entry |
| commit_cnt | input | 3 | Number of oldest entries released this cycle |
| flush_valid | input | 1 | Misprediction cut |
| flush_slot | input | 4 | Youngest slot that survives the cut |

## Verification
A corrupted ring pointer or occupancy count shows at `alloc_slot` and `alloc_ready` on the cycle after the faulty edge. It can also make an entry that should have been removed appear on the issue port. A stale per-entry flag, such as an issued, address or operand bit, shows up as a wrong or repeated `issue_slot`. This happens on the first cycle the entry should have been eligible, or should have been held back. A faulty ordering comparison lets a blocked load or store overtake its older store. That shows up as an out-of-order pop in the issue scoreboard one cycle after the enabling address write.

// File: rtl/mq_pkg.sv
// Package: shared types for the memory issue queue.
// Assumes: nothing beyond the enum encoding below.
package mq_pkg;

    // Kind of memory instruction held in a slot.
    typedef enum logic {
        MQ_LOAD  = 1'b0,
        MQ_STORE = 1'b1
    } mq_kind_e;

endpackage

// File: rtl/mq_ring_ctrl.sv
// Ring control: head pointer, occupancy, per-slot age rank and liveness.
// Assumes DEPTH is a power of two, that commit_cnt never exceeds the
// occupancy, and that flush_slot names a live slot whenever flush_valid is high.
module mq_ring_ctrl #(
    parameter int DEPTH      = 16,
    parameter int COMMIT_MAX = 4,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int CNT_W     = IDX_W + 1,
    localparam int CMT_W     = $clog2(COMMIT_MAX + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            alloc_req,
    input  logic [CMT_W-1:0]                commit_cnt,
    input  logic                            flush_valid,
    input  logic [IDX_W-1:0]                flush_slot,
    output logic                            alloc_fire_o,
    output logic                            alloc_ready_o,
    output logic [IDX_W-1:0]                head_o,
    output logic [IDX_W-1:0]                tail_o,
    output logic [DEPTH-1:0]                live_o,
    output logic [DEPTH-1:0][IDX_W-1:0]     rank_o
);

    logic [IDX_W-1:0] head_q;
    logic [CNT_W-1:0] count_q;
    logic [IDX_W-1:0] flush_rank;

    assign flush_rank    = flush_slot - head_q;
    assign alloc_ready_o = count_q < CNT_W'(DEPTH);
    assign alloc_fire_o  = alloc_req && alloc_ready_o && !flush_valid;
    assign head_o        = head_q;
    assign tail_o        = head_q + count_q[IDX_W-1:0];

    // Per slot: distance from the oldest end, and whether it survives this cycle.
    for (genvar g = 0; g < DEPTH; g++) begin : g_rank
        always_comb begin
            rank_o[g] = IDX_W'(g) - head_q;
            live_o[g] = (CNT_W'(rank_o[g]) < count_q)
                        && !(flush_valid && (rank_o[g] > flush_rank));
        end
    end

    // Advance head on commit; recompute occupancy on allocation, commit or flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            count_q <= '0;
        end else begin
            head_q <= head_q + IDX_W'(commit_cnt);
            if (flush_valid) begin
                count_q <= CNT_W'(flush_rank) + CNT_W'(1) - CNT_W'(commit_cnt);
            end else begin
                count_q <= count_q + CNT_W'(alloc_fire_o) - CNT_W'(commit_cnt);
            end
        end
    end

endmodule

// File: rtl/mq_slot_array.sv
// Slot storage: kind, operand wait tag and ready bit, address, issued bit.
// Assumes at most one allocation, one address write and one issue per cycle.
// Allocation resets the per-slot status bits; an address write to the slot
// being allocated in the same cycle is not kept.
module mq_slot_array
    import mq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int PREG_W = 6,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             alloc_we,
    input  logic [IDX_W-1:0]                 alloc_idx,
    input  mq_kind_e                         alloc_kind,
    input  logic [PREG_W-1:0]                alloc_src_tag,
    input  logic                             alloc_src_rdy,
    input  logic                             cdb_valid,
    input  logic [PREG_W-1:0]                cdb_tag,
    input  logic                             agu_valid,
    input  logic [IDX_W-1:0]                 agu_idx,
    input  logic [ADDR_W-1:0]                agu_addr,
    input  logic                             iss_we,
    input  logic [IDX_W-1:0]                 iss_idx,
    output logic [DEPTH-1:0]                 is_store_o,
    output logic [DEPTH-1:0]                 opnd_rdy_o,
    output logic [DEPTH-1:0]                 addr_ok_o,
    output logic [DEPTH-1:0]                 issued_o,
    output logic [DEPTH-1:0][ADDR_W-1:0]     addr_o
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [PREG_W-1:0] wait_tag_q;
        logic              hit_alloc;
        logic              hit_agu;
        logic              hit_iss;

        assign hit_alloc = alloc_we && (alloc_idx == IDX_W'(g));
        assign hit_agu   = agu_valid && (agu_idx == IDX_W'(g));
        assign hit_iss   = iss_we && (iss_idx == IDX_W'(g));

        // Update one slot from allocation, wakeup, address write and issue.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                is_store_o[g] <= 1'b0;
                opnd_rdy_o[g] <= 1'b0;
                addr_ok_o[g]  <= 1'b0;
                issued_o[g]   <= 1'b0;
                addr_o[g]     <= '0;
                wait_tag_q    <= '0;
            end else if (hit_alloc) begin
                is_store_o[g] <= (alloc_kind == MQ_STORE);
                wait_tag_q    <= alloc_src_tag;
                opnd_rdy_o[g] <= alloc_src_rdy || (cdb_valid && (cdb_tag == alloc_src_tag));
                addr_ok_o[g]  <= 1'b0;
                issued_o[g]   <= 1'b0;
            end else begin
                if (cdb_valid && (cdb_tag == wait_tag_q)) begin
                    opnd_rdy_o[g] <= 1'b1;
                end
                if (hit_agu) begin
                    addr_ok_o[g] <= 1'b1;
                    addr_o[g]    <= agu_addr;
                end
                if (hit_iss) begin
                    issued_o[g] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mq_order_check.sv
// Ordering check: holds back a slot while an older live store has no
// address, or, for a store, while an older live store has an equal address.
// Assumes rank gives each live slot a distinct age, smaller meaning older.
module mq_order_check #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]                 live,
    input  logic [DEPTH-1:0][IDX_W-1:0]      rank,
    input  logic [DEPTH-1:0]                 is_store,
    input  logic [DEPTH-1:0]                 addr_ok,
    input  logic [DEPTH-1:0][ADDR_W-1:0]     addr,
    output logic [DEPTH-1:0]                 hold_o
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        // Scan every other slot for an older store that blocks slot i.
        always_comb begin
            hold_o[i] = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (live[j] && is_store[j] && (rank[j] < rank[i])) begin
                    if (!addr_ok[j] || (is_store[i] && (addr[j] == addr[i]))) begin
                        hold_o[i] = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/mq_age_pick.sv
// Age picker: grants the requesting slot closest to the ring head.
// Assumes DEPTH is a power of two so slot arithmetic wraps naturally.
module mq_age_pick #(
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]   req,
    input  logic [IDX_W-1:0]   head,
    output logic               gnt_valid_o,
    output logic [IDX_W-1:0]   gnt_idx_o
);

    logic [IDX_W-1:0] cand;

    // Walk from youngest to oldest so the last hit is the oldest requester.
    always_comb begin
        gnt_valid_o = |req;
        gnt_idx_o   = '0;
        cand        = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            cand = head + IDX_W'(k);
            if (req[cand]) begin
                gnt_idx_o = cand;
            end
        end
    end

endmodule

// File: rtl/mem_addr_queue.sv
// Memory issue queue top: allocates in program order, tracks operand and
// address readiness, and offers the oldest entry that passes the ordering
// check to the load/store unit once per cycle.
// Assumes the load/store unit always accepts the offered entry, commits
// only issued entries from the oldest end, and flushes to a live slot.
module mem_addr_queue
    import mq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int ADDR_W     = 32,
    parameter int PREG_W     = 6,
    parameter int COMMIT_MAX = 4,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int CMT_W     = $clog2(COMMIT_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_valid,
    input  logic                alloc_is_store,
    input  logic [PREG_W-1:0]   alloc_src_tag,
    input  logic                alloc_src_rdy,
    output logic                alloc_ready,
    output logic [IDX_W-1:0]    alloc_slot,
    input  logic                cdb_valid,
    input  logic [PREG_W-1:0]   cdb_tag,
    input  logic                agu_valid,
    input  logic [IDX_W-1:0]    agu_slot,
    input  logic [ADDR_W-1:0]   agu_addr,
    output logic                issue_valid,
    output logic [IDX_W-1:0]    issue_slot,
    output logic                issue_is_store,
    output logic [ADDR_W-1:0]   issue_addr,
    input  logic [CMT_W-1:0]    commit_cnt,
    input  logic                flush_valid,
    input  logic [IDX_W-1:0]    flush_slot
);

    logic                          alloc_fire;
    logic [IDX_W-1:0]              head_idx;
    logic [DEPTH-1:0]              live;
    logic [DEPTH-1:0][IDX_W-1:0]   rank;
    logic [DEPTH-1:0]              is_store;
    logic [DEPTH-1:0]              opnd_rdy;
    logic [DEPTH-1:0]              addr_ok;
    logic [DEPTH-1:0]              issued;
    logic [DEPTH-1:0][ADDR_W-1:0]  addr;
    logic [DEPTH-1:0]              hold;
    logic [DEPTH-1:0]              eligible;
    mq_kind_e                      alloc_kind;

    assign alloc_kind = alloc_is_store ? MQ_STORE : MQ_LOAD;

    mq_ring_ctrl #(
        .DEPTH      (DEPTH),
        .COMMIT_MAX (COMMIT_MAX)
    ) u_ring (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc_req     (alloc_valid),
        .commit_cnt    (commit_cnt),
        .flush_valid   (flush_valid),
        .flush_slot    (flush_slot),
        .alloc_fire_o  (alloc_fire),
        .alloc_ready_o (alloc_ready),
        .head_o        (head_idx),
        .tail_o        (alloc_slot),
        .live_o        (live),
        .rank_o        (rank)
    );

    mq_slot_array #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .PREG_W (PREG_W)
    ) u_slots (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc_we      (alloc_fire),
        .alloc_idx     (alloc_slot),
        .alloc_kind    (alloc_kind),
        .alloc_src_tag (alloc_src_tag),
        .alloc_src_rdy (alloc_src_rdy),
        .cdb_valid     (cdb_valid),
        .cdb_tag       (cdb_tag),
        .agu_valid     (agu_valid),
        .agu_idx       (agu_slot),
        .agu_addr      (agu_addr),
        .iss_we        (issue_valid),
        .iss_idx       (issue_slot),
        .is_store_o    (is_store),
        .opnd_rdy_o    (opnd_rdy),
        .addr_ok_o     (addr_ok),
        .issued_o      (issued),
        .addr_o        (addr)
    );

    mq_order_check #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_order (
        .live     (live),
        .rank     (rank),
        .is_store (is_store),
        .addr_ok  (addr_ok),
        .addr     (addr),
        .hold_o   (hold)
    );

    // A slot competes when live, operand ready, address known, not yet sent, not held.
    assign eligible = live & opnd_rdy & addr_ok & ~issued & ~hold;

    mq_age_pick #(
        .DEPTH (DEPTH)
    ) u_pick (
        .req         (eligible),
        .head        (head_idx),
        .gnt_valid_o (issue_valid),
        .gnt_idx_o   (issue_slot)
    );

    // Present the granted slot's kind and address to the load/store unit.
    always_comb begin
        issue_is_store = is_store[issue_slot];
        issue_addr     = addr[issue_slot];
    end

endmodule

// File: rtl/mq_checker.sv
// Checker: temporal properties of the memory issue queue, bound to its top.
// Assumes the same parameters as the bound instance.
module mq_checker #(
    parameter int DEPTH      = 16,
    parameter int COMMIT_MAX = 4,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int CMT_W     = $clog2(COMMIT_MAX + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               alloc_ready,
    input logic               flush_valid,
    input logic [IDX_W-1:0]   flush_slot,
    input logic [CMT_W-1:0]   commit_cnt,
    input logic               issue_valid,
    input logic [IDX_W-1:0]   issue_slot,
    input logic [IDX_W-1:0]   head_idx
);

    logic [IDX_W-1:0] age_issue;
    logic [IDX_W-1:0] age_flush;

    assign age_issue = issue_slot - head_idx;
    assign age_flush = flush_slot - head_idx;

    // R1: a full queue stays full unless something leaves it.
    assert_full_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_ready && !flush_valid && commit_cnt == '0) |=> !alloc_ready);

    // R6: the same slot is never offered on two consecutive cycles.
    assert_single_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !(issue_valid && issue_slot == $past(issue_slot)));

    // R7: during a flush only surviving slots may be offered.
    assert_flush_scope_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && issue_valid) |-> (age_issue <= age_flush));

    // R8: any release leaves room on the next cycle.
    assert_commit_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_cnt != '0) |=> alloc_ready);

endmodule

bind mem_addr_queue mq_checker #(
    .DEPTH      (DEPTH),
    .COMMIT_MAX (COMMIT_MAX)
) u_mq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_ready (alloc_ready),
    .flush_valid (flush_valid),
    .flush_slot  (flush_slot),
    .commit_cnt  (commit_cnt),
    .issue_valid (issue_valid),
    .issue_slot  (issue_slot),
    .head_idx    (head_idx)
);

// File: tb/mem_addr_queue_tb.sv
// Scoreboard bench: stimulus tasks queue the expected issue order; a monitor
// compares every offered entry against the head of that queue.
module mem_addr_queue_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic        alloc_is_store = 1'b0;
    logic [5:0]  alloc_src_tag = '0;
    logic        alloc_src_rdy = 1'b0;
    logic        alloc_ready;
    logic [3:0]  alloc_slot;
    logic        cdb_valid = 1'b0;
    logic [5:0]  cdb_tag = '0;
    logic        agu_valid = 1'b0;
    logic [3:0]  agu_slot = '0;
    logic [31:0] agu_addr = '0;
    logic        issue_valid;
    logic [3:0]  issue_slot;
    logic        issue_is_store;
    logic [31:0] issue_addr;
    logic [2:0]  commit_cnt = '0;
    logic        flush_valid = 1'b0;
    logic [3:0]  flush_slot = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0]  slot;
        logic        st;
        logic [31:0] addr;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    mem_addr_queue u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .alloc_valid    (alloc_valid),
        .alloc_is_store (alloc_is_store),
        .alloc_src_tag  (alloc_src_tag),
        .alloc_src_rdy  (alloc_src_rdy),
        .alloc_ready    (alloc_ready),
        .alloc_slot     (alloc_slot),
        .cdb_valid      (cdb_valid),
        .cdb_tag        (cdb_tag),
        .agu_valid      (agu_valid),
        .agu_slot       (agu_slot),
        .agu_addr       (agu_addr),
        .issue_valid    (issue_valid),
        .issue_slot     (issue_slot),
        .issue_is_store (issue_is_store),
        .issue_addr     (issue_addr),
        .commit_cnt     (commit_cnt),
        .flush_valid    (flush_valid),
        .flush_slot     (flush_slot)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic push_exp(input logic [3:0] s, input logic st, input logic [31:0] a, input string r);
        exp_t e;
        e.slot = s; e.st = st; e.addr = a; e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic do_alloc(input logic st, input logic [5:0] tag, input logic rdy);
        alloc_valid = 1'b1; alloc_is_store = st; alloc_src_tag = tag; alloc_src_rdy = rdy;
        step();
        alloc_valid = 1'b0;
    endtask

    task automatic do_agu(input logic [3:0] s, input logic [31:0] a);
        agu_valid = 1'b1; agu_slot = s; agu_addr = a;
        step();
        agu_valid = 1'b0;
    endtask

    task automatic do_cdb(input logic [5:0] tag);
        cdb_valid = 1'b1; cdb_tag = tag;
        step();
        cdb_valid = 1'b0;
    endtask

    task automatic do_commit(input logic [2:0] n);
        commit_cnt = n;
        step();
        commit_cnt = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: every offered entry must match the next expected one.
    always @(negedge clk) begin : mon
        exp_t e;
        if (rst_n && !done && issue_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R6 unexpected issue: actual slot %0d expected none", issue_slot);
            end else begin
                e = exp_q.pop_front();
                if (issue_slot !== e.slot || issue_is_store !== e.st || issue_addr !== e.addr) begin
                    n_fail++;
                    $display("FAIL %s issue: actual slot %0d st %0b addr %0h expected slot %0d st %0b addr %0h",
                             e.req, issue_slot, issue_is_store, issue_addr, e.slot, e.st, e.addr);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 ready after reset", alloc_ready, 1);
        chk("R9 no issue after reset", issue_valid, 0);
        chk("R9 first slot", alloc_slot, 0);

        // R2/R5: younger ready load overtakes older waiting load.
        do_alloc(1'b0, 6'd5, 1'b0);
        do_alloc(1'b0, 6'd7, 1'b1);
        push_exp(4'd1, 1'b0, 32'h100, "R5");
        do_agu(4'd1, 32'h100);
        do_agu(4'd0, 32'h200);
        idle(3);
        push_exp(4'd0, 1'b0, 32'h200, "R2");
        do_cdb(6'd5);
        idle(2);
        chk("R2 drained", exp_q.size(), 0);
        do_commit(3'd2);
        @(negedge clk);
        chk("R8 slot after commit", alloc_slot, 2);

        // R3/R6: load waits on older store with unknown address.
        do_alloc(1'b1, 6'd1, 1'b1);
        do_alloc(1'b0, 6'd2, 1'b1);
        do_agu(4'd3, 32'h40);
        idle(3);
        push_exp(4'd2, 1'b1, 32'h80, "R6");
        push_exp(4'd3, 1'b0, 32'h40, "R3");
        do_agu(4'd2, 32'h80);
        idle(3);
        chk("R3 drained", exp_q.size(), 0);
        do_commit(3'd2);

        // R4: store waits on older store with equal address until it commits.
        do_alloc(1'b1, 6'd1, 1'b1);
        do_alloc(1'b1, 6'd1, 1'b1);
        do_alloc(1'b1, 6'd1, 1'b1);
        push_exp(4'd4, 1'b1, 32'h300, "R4");
        do_agu(4'd4, 32'h300);
        do_agu(4'd5, 32'h300);
        push_exp(4'd6, 1'b1, 32'h310, "R4");
        do_agu(4'd6, 32'h310);
        idle(3);
        chk("R4 same-address store held", exp_q.size(), 0);
        push_exp(4'd5, 1'b1, 32'h300, "R4");
        do_commit(3'd1);
        idle(2);
        chk("R4 drained", exp_q.size(), 0);
        do_commit(3'd2);
        @(negedge clk);
        chk("R8 slot before fill", alloc_slot, 7);

        // R1/R8: fill, refuse, release four, refill exactly four.
        for (int k = 0; k < 16; k++) do_alloc(1'b0, 6'd0, 1'b1);
        @(negedge clk);
        chk("R1 full stalls", alloc_ready, 0);
        do_alloc(1'b0, 6'd0, 1'b1);
        for (int k = 0; k < 4; k++) begin
            push_exp(4'(7 + k), 1'b0, 32'h1000 + 32'(k), "R8");
            do_agu(4'(7 + k), 32'h1000 + 32'(k));
        end
        idle(2);
        chk("R8 drained", exp_q.size(), 0);
        do_commit(3'd4);
        @(negedge clk);
        chk("R8 ready after release", alloc_ready, 1);
        chk("R8 slot after release", alloc_slot, 7);
        for (int k = 0; k < 3; k++) do_alloc(1'b0, 6'd0, 1'b1);
        @(negedge clk);
        chk("R1 room for fourth", alloc_ready, 1);
        do_alloc(1'b0, 6'd0, 1'b1);
        @(negedge clk);
        chk("R1 refused alloc not counted", alloc_ready, 0);

        // R7: flush keeps slots 11,12 and hides eligible slot 14 in the same cycle.
        do_agu(4'd14, 32'h500);
        flush_valid = 1'b1; flush_slot = 4'd12;
        step();
        flush_valid = 1'b0;
        @(negedge clk);
        chk("R7 slot after flush", alloc_slot, 13);
        chk("R7 room after flush", alloc_ready, 1);
        idle(3);
        flush_valid = 1'b1; flush_slot = 4'd12; alloc_valid = 1'b1;
        step();
        flush_valid = 1'b0; alloc_valid = 1'b0;
        @(negedge clk);
        chk("R7 alloc dropped during flush", alloc_slot, 13);
        do_alloc(1'b0, 6'd0, 1'b1);
        @(negedge clk);
        chk("R7 slot reused", alloc_slot, 14);
        push_exp(4'd11, 1'b0, 32'h600, "R7");
        do_agu(4'd11, 32'h600);
        push_exp(4'd12, 1'b0, 32'h610, "R7");
        do_agu(4'd12, 32'h610);
        push_exp(4'd13, 1'b0, 32'h620, "R7");
        do_agu(4'd13, 32'h620);
        idle(2);
        chk("R7 drained", exp_q.size(), 0);
        do_commit(3'd3);
        @(negedge clk);
        chk("R9 empty at end", alloc_slot, 14);
        chk("R6 no pending issue", issue_valid, 0);
        finish_run();
    end

endmodule